// File: doc/BRIEF.md
# NAND Die Command Acceptance Tracker

This block is a device-side behavioural responder for a single flash die on an asynchronous 8-bit command/address/data bus. It watches command-latch and address-latch write cycles. It tracks a pending command sequence and decides, from two readiness flags, whether each command is taken or dropped. It then models the timed busy phases that the accepted commands start.

Readiness is split into two flags. The interface flag (RDY) says the die can take new commands. The array flag (ARDY) says no operation is running inside the array. A cache program or cache read first holds both flags low for a short transfer time. After that, RDY returns high while ARDY stays low for the array time, and some commands remain legal in that window.

The die answers status reads only while it is the selected die. A plain status command selects every die. An addressed status command selects this die only when the die field of its last row byte matches the die's own number. The block also raises a data-output flag after a column change and pulses a cache-clear strobe when a program sequence opens. It is meant as a checkable partner for host-side sequencers.

Top module: `nand_die_tracker`

## Requirements
- R1: After reset, rdy_o=1, ardy_o=1, rb_n_o=1, dout_mode_o=0, cache_clr_o=0, io_oe_o=0, and the die is selected.
- R2: A 15h command closing a program sequence (80h, then COL_CYCLES+ROW_CYCLES address cycles) drives RDY=0 and ARDY=0 for T_CBSY clocks. Then RDY=1 with ARDY=0 for T_PROG clocks. Then ARDY=1. ARDY is never 1 while RDY is 0.
- R3: 80h is accepted when RDY=1 and either ARDY=1 or a cache program's array phase is running. In every other state it is ignored.
- R4: 05h is accepted whenever RDY=1, whatever ARDY is. After COL_CYCLES address cycles, E0h is accepted and sets data-output mode.
- R5: Data-output mode stays set until another accepted command arrives. Ignored commands do not clear it.
- R6: 78h followed by ROW_CYCLES address cycles selects the die only when bits [LUN_BITS-1:0] of the last row byte equal LUN_ID. Otherwise the die is deselected. 70h selects the die. dout_mode_o and io_oe_o are 0 while the die is deselected.
- R7: In status mode (after 70h, or a matching 78h), with re_i=1, io_oe_o=1 and io_o = {1, RDY, ARDY, 5'b0}. Bit 6 is RDY and bit 5 is ARDY. Any other accepted command leaves status mode.
- R8: An accepted 80h pulses cache_clr_o for one clock, unless the last accepted closing command was 11h.
- R9: rb_n_o is 0 exactly while RDY=0.
- R10: 10h closing a program sequence is accepted only with ARDY=1. It holds RDY=0 and ARDY=0 for T_PROG clocks.
- R11: 31h is accepted when RDY=1 and either ARDY=1 or a cache read's array phase is running. It gives T_CBSY clocks fully busy, then T_RD clocks with ARDY=0.
- R12: Unknown command bytes, out-of-order closing commands and commands not allowed in the current state are ignored. They leave all flags and modes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle_i | input | 1 | Command latch qualifier |
| ale_i | input | 1 | Address latch qualifier |
| we_i | input | 1 | One-clock write strobe for the bus byte |
| re_i | input | 1 | Read request for the status byte |
| io_i | input | 8 | Bus byte written by the host |
| io_o | output | 8 | Status byte driven to the host |
| io_oe_o | output | 1 | Output enable for io_o |
| rdy_o | output | 1 | Interface-ready flag |
| ardy_o | output | 1 | Array-ready flag |
| rb_n_o | output | 1 | Ready/busy, low while busy (open-drain style) |
| dout_mode_o | output | 1 | Die is in data-output mode and selected |
| cache_clr_o | output | 1 | One-clock pulse: cache register cleared |

## Verification
A wrong readiness state shows up one clock after the offending command edge. It appears as a wrong rdy_o, ardy_o or rb_n_o, or as a command wrongly taken or dropped: an unexpected cache_clr_o pulse, a wrong dout_mode_o edge, or a busy phase that starts when it should not. A miscounted timer shows up only at the end of a busy phase, up to T_PROG clocks later. The per-clock comparison against an independent model catches it on the exact clock. A wrong die selection or status mode is seen on the next clock that has re_i high, through io_oe_o and the status byte.

// File: rtl/nand_trk_pkg.sv
package nand_trk_pkg;

  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_STATSEL = 8'h78;
  localparam logic [7:0] OP_COLCHG  = 8'h05;
  localparam logic [7:0] OP_COLGO   = 8'hE0;
  localparam logic [7:0] OP_PROPEN  = 8'h80;
  localparam logic [7:0] OP_PREND   = 8'h10;
  localparam logic [7:0] OP_PRPLANE = 8'h11;
  localparam logic [7:0] OP_PRCACHE = 8'h15;
  localparam logic [7:0] OP_RDCACHE = 8'h31;

  // one accepted event per clock at most
  typedef enum logic [3:0] {
    EV_NONE, EV_STAT, EV_SEL_START, EV_SEL_DONE, EV_COL, EV_COL_GO,
    EV_PRG_OPEN, EV_PRG_END, EV_PRG_PLANE, EV_PRG_CACHE, EV_RD_CACHE
  } ev_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_COL, SQ_PRG, SQ_SEL} seq_t;

  typedef enum logic [1:0] {AK_NONE, AK_PROG, AK_READ} ak_t;

endpackage

// File: rtl/nand_trk_decode.sv
module nand_trk_decode
  import nand_trk_pkg::*;
#(
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3,
  parameter int LUN_BITS   = 1,
  parameter int LUN_ID     = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we,
  input  logic [7:0] io,
  input  logic       rdy,
  input  logic       ardy,
  input  ak_t        arr_kind,
  output ev_t        ev,
  output logic       lun_hit
);

  localparam int PRG_ADR = COL_CYCLES + ROW_CYCLES;
  localparam int AW      = $clog2(PRG_ADR + 1);

  seq_t          seq_q, seq_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cmd_stb, adr_stb, prg_full, col_full, seq_en;

  assign cmd_stb  = we & cle & ~ale;
  assign adr_stb  = we & ale & ~cle;
  assign prg_full = (seq_q == SQ_PRG) && (cnt_q == AW'(PRG_ADR));
  assign col_full = (seq_q == SQ_COL) && (cnt_q == AW'(COL_CYCLES));
  assign seq_en   = cmd_stb | adr_stb;

  always_comb begin
    ev      = EV_NONE;
    seq_d   = seq_q;
    cnt_d   = cnt_q;
    lun_hit = 1'b0;
    if (cmd_stb) begin
      case (io)
        OP_STATUS: begin
          ev = EV_STAT; seq_d = SQ_IDLE;
        end
        OP_STATSEL: begin
          ev = EV_SEL_START; seq_d = SQ_SEL; cnt_d = '0;
        end
        OP_COLCHG: if (rdy) begin
          ev = EV_COL; seq_d = SQ_COL; cnt_d = '0;
        end
        OP_COLGO: if (rdy && col_full) begin
          ev = EV_COL_GO; seq_d = SQ_IDLE;
        end
        OP_PROPEN: if (rdy && (ardy || arr_kind == AK_PROG)) begin
          ev = EV_PRG_OPEN; seq_d = SQ_PRG; cnt_d = '0;
        end
        OP_PREND: if (rdy && ardy && prg_full) begin
          ev = EV_PRG_END; seq_d = SQ_IDLE;
        end
        OP_PRPLANE: if (rdy && prg_full) begin
          ev = EV_PRG_PLANE; seq_d = SQ_IDLE;
        end
        OP_PRCACHE: if (rdy && prg_full) begin
          ev = EV_PRG_CACHE; seq_d = SQ_IDLE;
        end
        OP_RDCACHE: if (rdy && (ardy || arr_kind == AK_READ)) begin
          ev = EV_RD_CACHE; seq_d = SQ_IDLE;
        end
        default: ;
      endcase
    end else if (adr_stb) begin
      case (seq_q)
        SQ_SEL: begin
          if (cnt_q == AW'(ROW_CYCLES - 1)) begin
            ev      = EV_SEL_DONE;
            lun_hit = (io[LUN_BITS-1:0] == LUN_BITS'(LUN_ID));
            seq_d   = SQ_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_COL: if (cnt_q < AW'(COL_CYCLES)) cnt_d = cnt_q + 1'b1;
        SQ_PRG: if (cnt_q < AW'(PRG_ADR))    cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      cnt_q <= '0;
    end else if (seq_en) begin
      seq_q <= seq_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_trk_ready.sv
module nand_trk_ready
  import nand_trk_pkg::*;
#(
  parameter int T_CBSY = 4,
  parameter int T_PROG = 24,
  parameter int T_RD   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  ev_t  ev,
  output logic rdy,
  output logic ardy,
  output ak_t  arr_kind
);

  localparam int TMAX = (T_PROG > T_RD) ? ((T_PROG > T_CBSY) ? T_PROG : T_CBSY)
                                        : ((T_RD > T_CBSY) ? T_RD : T_CBSY);
  localparam int CW   = $clog2(TMAX + 1);

  logic          rdy_q, rdy_d, ardy_q, ardy_d, tick_en;
  logic [CW-1:0] cnt_q, cnt_d;
  ak_t           pend_q, pend_d, kind_q, kind_d;

  assign tick_en = (ev == EV_PRG_END) || (ev == EV_PRG_CACHE) ||
                   (ev == EV_RD_CACHE) || !rdy_q || !ardy_q;

  always_comb begin
    rdy_d  = rdy_q;
    ardy_d = ardy_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    kind_d = kind_q;
    case (ev)
      EV_PRG_END: begin
        rdy_d = 1'b0; ardy_d = 1'b0; cnt_d = CW'(T_PROG);
        pend_d = AK_NONE; kind_d = AK_NONE;
      end
      EV_PRG_CACHE: begin
        rdy_d = 1'b0; ardy_d = 1'b0; cnt_d = CW'(T_CBSY);
        pend_d = AK_PROG; kind_d = AK_NONE;
      end
      EV_RD_CACHE: begin
        rdy_d = 1'b0; ardy_d = 1'b0; cnt_d = CW'(T_CBSY);
        pend_d = AK_READ; kind_d = AK_NONE;
      end
      default: begin
        if (!rdy_q) begin
          if (cnt_q == CW'(1)) begin
            rdy_d  = 1'b1;
            pend_d = AK_NONE;
            if (pend_q == AK_NONE) begin
              ardy_d = 1'b1;
            end else begin
              kind_d = pend_q;
              cnt_d  = (pend_q == AK_PROG) ? CW'(T_PROG) : CW'(T_RD);
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end else if (!ardy_q) begin
          if (cnt_q == CW'(1)) begin
            ardy_d = 1'b1;
            kind_d = AK_NONE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      ardy_q <= 1'b1;
      cnt_q  <= '0;
      pend_q <= AK_NONE;
      kind_q <= AK_NONE;
    end else if (tick_en) begin
      rdy_q  <= rdy_d;
      ardy_q <= ardy_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      kind_q <= kind_d;
    end
  end

  assign rdy      = rdy_q;
  assign ardy     = ardy_q;
  assign arr_kind = kind_q;

endmodule

// File: rtl/nand_trk_status.sv
module nand_trk_status
  import nand_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ev_t        ev,
  input  logic       lun_hit,
  input  logic       re,
  input  logic       rdy,
  input  logic       ardy,
  output logic [7:0] stat_byte,
  output logic       stat_oe,
  output logic       dout_mode,
  output logic       cache_clr
);

  logic stat_q, stat_d, sel_q, sel_d, dout_q, dout_d;
  logic plane_q, plane_d, clr_q, clr_d, mode_en;

  assign mode_en = (ev != EV_NONE) || clr_q;

  always_comb begin
    stat_d  = stat_q;
    sel_d   = sel_q;
    dout_d  = dout_q;
    plane_d = plane_q;
    clr_d   = 1'b0;
    if (ev != EV_NONE) begin
      stat_d = 1'b0;
      dout_d = 1'b0;
    end
    case (ev)
      EV_STAT:      begin stat_d = 1'b1; sel_d = 1'b1;    end
      EV_SEL_DONE:  begin stat_d = 1'b1; sel_d = lun_hit; end
      EV_COL_GO:    dout_d = 1'b1;
      EV_PRG_OPEN:  clr_d = !plane_q;
      EV_PRG_PLANE: plane_d = 1'b1;
      EV_PRG_END,
      EV_PRG_CACHE: plane_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      sel_q   <= 1'b1;
      dout_q  <= 1'b0;
      plane_q <= 1'b0;
      clr_q   <= 1'b0;
    end else if (mode_en) begin
      stat_q  <= stat_d;
      sel_q   <= sel_d;
      dout_q  <= dout_d;
      plane_q <= plane_d;
      clr_q   <= clr_d;
    end
  end

  assign stat_oe   = re & stat_q & sel_q;
  assign stat_byte = stat_oe ? {1'b1, rdy, ardy, 5'b0} : 8'h00;
  assign dout_mode = dout_q & sel_q;
  assign cache_clr = clr_q;

endmodule

// File: rtl/nand_die_tracker.sv
module nand_die_tracker
  import nand_trk_pkg::*;
#(
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3,
  parameter int LUN_BITS   = 1,
  parameter int LUN_ID     = 0,
  parameter int T_CBSY     = 4,
  parameter int T_PROG     = 24,
  parameter int T_RD       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rdy_o,
  output logic       ardy_o,
  output logic       rb_n_o,
  output logic       dout_mode_o,
  output logic       cache_clr_o
);

  logic [1:0] rsync_q;
  logic       srst_n, lun_hit, rdy, ardy;
  ev_t        ev;
  ak_t        arr_kind;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  nand_trk_decode #(
    .COL_CYCLES(COL_CYCLES), .ROW_CYCLES(ROW_CYCLES),
    .LUN_BITS(LUN_BITS), .LUN_ID(LUN_ID)
  ) u_dec (
    .clk(clk), .rst_n(srst_n), .cle(cle_i), .ale(ale_i), .we(we_i),
    .io(io_i), .rdy(rdy), .ardy(ardy), .arr_kind(arr_kind),
    .ev(ev), .lun_hit(lun_hit)
  );

  nand_trk_ready #(
    .T_CBSY(T_CBSY), .T_PROG(T_PROG), .T_RD(T_RD)
  ) u_rdy (
    .clk(clk), .rst_n(srst_n), .ev(ev),
    .rdy(rdy), .ardy(ardy), .arr_kind(arr_kind)
  );

  nand_trk_status u_st (
    .clk(clk), .rst_n(srst_n), .ev(ev), .lun_hit(lun_hit), .re(re_i),
    .rdy(rdy), .ardy(ardy), .stat_byte(io_o), .stat_oe(io_oe_o),
    .dout_mode(dout_mode_o), .cache_clr(cache_clr_o)
  );

  assign rdy_o  = rdy;
  assign ardy_o = ardy;
  assign rb_n_o = rdy;

endmodule

// File: rtl/nand_die_tracker_chk.sv
module nand_die_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_i,
  input logic [7:0] io_i,
  input logic [7:0] io_o,
  input logic       io_oe_o,
  input logic       rdy_o,
  input logic       ardy_o,
  input logic       dout_mode_o,
  input logic       cache_clr_o
);

  AST_ARDY_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> !ardy_o); // R2

  AST_ARDY_RISE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ardy_o) |-> rdy_o); // R2

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(we_i && cle_i && !ale_i &&
      (io_i == 8'h10 || io_i == 8'h15 || io_i == 8'h31))); // R12

  AST_CLR_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cache_clr_o |-> $past(we_i && cle_i && !ale_i && io_i == 8'h80)); // R8

  AST_DOUT_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_mode_o) |-> $past(we_i && cle_i && !ale_i && io_i == 8'hE0)); // R4

  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe_o |-> (io_o[7] && io_o[6] == rdy_o && io_o[5] == ardy_o &&
                 io_o[4:0] == 5'b0)); // R7

endmodule

bind nand_die_tracker nand_die_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cle_i(cle_i), .ale_i(ale_i), .we_i(we_i),
  .io_i(io_i), .io_o(io_o), .io_oe_o(io_oe_o), .rdy_o(rdy_o),
  .ardy_o(ardy_o), .dout_mode_o(dout_mode_o), .cache_clr_o(cache_clr_o)
);

// File: tb/nand_die_tracker_test.sv
module nand_die_tracker_test;

  localparam int CLK_PER = 10;
  localparam int NCOL = 2, NROW = 3, LB = 1, LID = 0;
  localparam int TCB = 4, TPR = 24, TRD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 1'b0, ale = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] io = 8'h00;
  logic [7:0] io_o;
  logic io_oe, rdy, ardy, rb_n, dout, clr;

  int n_cmp = 0, n_bad = 0;
  string ctx = "R1 reset";

  nand_die_tracker #(
    .COL_CYCLES(NCOL), .ROW_CYCLES(NROW), .LUN_BITS(LB), .LUN_ID(LID),
    .T_CBSY(TCB), .T_PROG(TPR), .T_RD(TRD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cle_i(cle), .ale_i(ale), .we_i(we), .re_i(re),
    .io_i(io), .io_o(io_o), .io_oe_o(io_oe), .rdy_o(rdy), .ardy_o(ardy),
    .rb_n_o(rb_n), .dout_mode_o(dout), .cache_clr_o(clr)
  );

  always #(CLK_PER/2) clk = ~clk;

  // reference model state
  bit m_rdy = 1, m_ardy = 1, m_stat = 0, m_sel = 1, m_dout = 0, m_plane = 0, m_clr = 0;
  int m_cnt = 0, m_pend = 0, m_kind = 0;   // kinds: 0 none, 1 program, 2 read
  int m_seq = 0, m_acnt = 0;               // seq: 0 idle, 1 col, 2 prog, 3 sel

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %h expected %h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic model_update(logic c, logic a, logic w, logic [7:0] d);
    bit cmd = w && c && !a;
    bit adr = w && a && !c;
    bit pfull = (m_seq == 2) && (m_acnt == NCOL + NROW);
    int ev = 0;   // 1 stat 2 selstart 3 seldone 4 col 5 colgo 6 open 7 end 8 plane 9 cache 10 rdcache
    bit hit = 0;
    if (cmd) begin
      case (d)
        8'h70: begin ev = 1; m_seq = 0; end
        8'h78: begin ev = 2; m_seq = 3; m_acnt = 0; end
        8'h05: if (m_rdy) begin ev = 4; m_seq = 1; m_acnt = 0; end
        8'hE0: if (m_rdy && m_seq == 1 && m_acnt == NCOL) begin ev = 5; m_seq = 0; end
        8'h80: if (m_rdy && (m_ardy || m_kind == 1)) begin ev = 6; m_seq = 2; m_acnt = 0; end
        8'h10: if (m_rdy && m_ardy && pfull) begin ev = 7; m_seq = 0; end
        8'h11: if (m_rdy && pfull) begin ev = 8; m_seq = 0; end
        8'h15: if (m_rdy && pfull) begin ev = 9; m_seq = 0; end
        8'h31: if (m_rdy && (m_ardy || m_kind == 2)) begin ev = 10; m_seq = 0; end
        default: ;
      endcase
    end else if (adr) begin
      if (m_seq == 3) begin
        if (m_acnt == NROW - 1) begin
          ev = 3; hit = (int'(d[LB-1:0]) == LID); m_seq = 0;
        end else m_acnt++;
      end else if (m_seq == 1 && m_acnt < NCOL) m_acnt++;
      else if (m_seq == 2 && m_acnt < NCOL + NROW) m_acnt++;
    end
    // modes
    m_clr = 0;
    if (ev != 0) begin m_stat = 0; m_dout = 0; end
    case (ev)
      1: begin m_stat = 1; m_sel = 1; end
      3: begin m_stat = 1; m_sel = hit; end
      5: m_dout = 1;
      6: m_clr = !m_plane;
      8: m_plane = 1;
      7, 9: m_plane = 0;
      default: ;
    endcase
    // readiness
    if (ev == 7) begin m_rdy = 0; m_ardy = 0; m_cnt = TPR; m_pend = 0; m_kind = 0; end
    else if (ev == 9) begin m_rdy = 0; m_ardy = 0; m_cnt = TCB; m_pend = 1; m_kind = 0; end
    else if (ev == 10) begin m_rdy = 0; m_ardy = 0; m_cnt = TCB; m_pend = 2; m_kind = 0; end
    else if (!m_rdy) begin
      if (m_cnt == 1) begin
        m_rdy = 1;
        if (m_pend == 0) m_ardy = 1;
        else begin m_kind = m_pend; m_cnt = (m_pend == 1) ? TPR : TRD; end
        m_pend = 0;
      end else m_cnt--;
    end else if (!m_ardy) begin
      if (m_cnt == 1) begin m_ardy = 1; m_kind = 0; end else m_cnt--;
    end
  endtask

  task automatic check_regs();
    cmp("R2 rdy", {7'b0, rdy}, {7'b0, m_rdy});
    cmp("R2 ardy", {7'b0, ardy}, {7'b0, m_ardy});
    cmp("R9 rb_n", {7'b0, rb_n}, {7'b0, m_rdy});
    cmp("R5 dout", {7'b0, dout}, {7'b0, m_dout && m_sel});
    cmp("R8 clr", {7'b0, clr}, {7'b0, m_clr});
  endtask

  // one bus clock: drive at falling edge, check io before rising edge, regs after it
  task automatic step(logic c, logic a, logic w, logic r, logic [7:0] d);
    bit eoe;
    @(negedge clk);
    cle = c; ale = a; we = w; re = r; io = d;
    #1;
    eoe = r && m_stat && m_sel;
    cmp("R7 oe", {7'b0, io_oe}, {7'b0, eoe});
    cmp("R7 byte", io_o, eoe ? {1'b1, m_rdy, m_ardy, 5'b0} : 8'h00);
    @(posedge clk);
    model_update(c, a, w, d);
    #1;
    check_regs();
  endtask

  task automatic cmd(logic [7:0] d);  step(1, 0, 1, 0, d); endtask
  task automatic adr(logic [7:0] d);  step(0, 1, 1, 0, d); endtask
  task automatic idle(int n, bit r = 0);
    for (int i = 0; i < n; i++) step(0, 0, 0, r, 8'h00);
  endtask
  task automatic prog_seq(logic [7:0] close);
    cmd(8'h80);
    for (int i = 0; i < NCOL + NROW; i++) adr(8'(i));
    cmd(close);
  endtask
  task automatic col_seq();
    cmd(8'h05); adr(8'h00); adr(8'h01); cmd(8'hE0);
  endtask
  task automatic sel_seq(logic [7:0] last);
    cmd(8'h78); adr(8'h00); adr(8'h00); adr(last);
  endtask

  task automatic expect1(string tag, logic act, logic exp);
    cmp(tag, {7'b0, act}, {7'b0, exp});
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset values
    expect1("R1 rdy", rdy, 1); expect1("R1 ardy", ardy, 1); expect1("R1 rb_n", rb_n, 1);
    expect1("R1 dout", dout, 0); expect1("R1 clr", clr, 0);
    idle(1, 1);
    expect1("R1 no status drive", io_oe, 0);

    // R2 cache program timing
    ctx = "R2 cache program";
    prog_seq(8'h15);
    expect1("R2 busy after 15h", rdy, 0);
    idle(TCB - 1);
    expect1("R2 still busy", rdy, 0);
    idle(1);
    expect1("R2 rdy back", rdy, 1); expect1("R2 array busy", ardy, 0);

    // R3 open during cache program is accepted
    ctx = "R3 open in cache program";
    cmd(8'h80);
    expect1("R3 clr pulse", clr, 1);
    idle(TPR);
    // R7 status bits
    ctx = "R7 status";
    cmd(8'h70); idle(2, 1);
    expect1("R7 oe", io_oe, 1);
    cmp("R7 byte idle", io_o, 8'hE0);

    // R11 cache read, R3 open ignored during it, R4 column change in it
    ctx = "R11 cache read";
    cmd(8'h31);
    expect1("R11 busy", rdy, 0);
    idle(TCB);
    expect1("R11 rdy", rdy, 1); expect1("R11 ardy", ardy, 0);
    ctx = "R3 open ignored in cache read";
    cmd(8'h80);
    expect1("R3 no clr", clr, 0);
    ctx = "R4 column change while array busy";
    col_seq();
    expect1("R4 dout set", dout, 1);
    ctx = "R5 ignored open keeps dout";
    cmd(8'h80);
    expect1("R5 dout kept", dout, 1);
    ctx = "R12 unknown byte";
    cmd(8'hA5);
    expect1("R12 dout kept", dout, 1);
    ctx = "R5 status clears dout";
    cmd(8'h70);
    expect1("R5 dout cleared", dout, 0);
    idle(TRD);

    // R6 selection
    ctx = "R6 mismatch";
    sel_seq(8'h01);
    idle(1, 1);
    expect1("R6 deselected no oe", io_oe, 0);
    col_seq();
    expect1("R6 deselected no dout", dout, 0);
    sel_seq(8'h02);
    idle(1, 1);
    expect1("R6 match oe", io_oe, 1);

    // R8 two-plane
    ctx = "R8 two plane";
    prog_seq(8'h11);
    cmd(8'h80);
    expect1("R8 no clr after plane", clr, 0);
    for (int i = 0; i < NCOL + NROW; i++) adr(8'h00);
    cmd(8'h15);
    idle(TCB + TPR);
    cmd(8'h80);
    expect1("R8 clr again", clr, 1);

    // R10 program end refused while array busy, accepted when idle
    ctx = "R10 end";
    for (int i = 0; i < NCOL + NROW; i++) adr(8'h00);
    cmd(8'h15); idle(TCB);
    cmd(8'h80); for (int i = 0; i < NCOL + NROW; i++) adr(8'h00);
    cmd(8'h10);
    expect1("R10 refused while array busy", rdy, 1);
    idle(TPR);
    cmd(8'h10);
    expect1("R10 accepted", rdy, 0);
    idle(TPR - 1);
    expect1("R10 still busy", rdy, 0);
    idle(1);
    expect1("R10 done", ardy, 1);
    ctx = "R12 E0h out of order";
    cmd(8'hE0);
    expect1("R12 no dout", dout, 0);

    // random mix
    ctx = "R12 random";
    for (int k = 0; k < 600; k++) begin
      int pick = int'($urandom_range(0, 9));
      case (pick)
        0: prog_seq(8'h15);
        1: prog_seq(8'h10);
        2: prog_seq(8'h11);
        3: col_seq();
        4: sel_seq(8'($urandom_range(0, 3)));
        5: cmd(8'h70);
        6: cmd(8'h31);
        7: cmd(8'($urandom));
        8: adr(8'($urandom));
        default: idle(int'($urandom_range(1, 12)), 1'($urandom));
      endcase
    end
    idle(40, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule